// File: doc/BRIEF.md
# Cycle Slip Reduction Current-Cell Controller

This block sits beside the charge pump of a fractional-N phase-locked loop. It decides how many extra constant-current cells are switched on to widen the linear range of the phase detector during frequency acquisition. The clock is the phase-detector comparison clock, so one clock cycle is one comparison cycle. A separate detector raises `slip_warn` for each cycle in which a slip is about to happen. `tune_up` gives the direction the VCO tuning voltage has to move. `overshoot` reports that the VCO frequency has moved past the target.

Each warning adds one cell, up to seven. The polarity of the added current is fixed when the first cell turns on. After overshoot the cells are withdrawn one at a time, at a programmable spacing of `decay_period` cycles. Once no cells remain, `settled` reports that the acquisition has finished. While enabled, the cell count and polarity are held as steady levels and are never pulsed.

The controller has three states: idle, ramp-up and ramp-down. Pulling `enable` low returns it to idle with no cells on.

Top module: `csr_cell_ctrl`

## Requirements
- R1: After reset, `cell_count` is 0, `cell_source` is 0 and `settled` is 0.
- R2: In idle, a cycle with `slip_warn` high sets `cell_count` to 1 on the next cycle and captures `tune_up` into `cell_source`. The encoding is 1 = source current (raise the tuning voltage) and 0 = sink current.
- R3: In ramp-up, each cycle with `slip_warn` high and `overshoot` low adds one cell. At 7 cells further warnings leave the count at 7.
- R4: `cell_source` changes only when the count goes from 0 to 1. While cells remain on, `tune_up` has no effect on it.
- R5: `overshoot` high in ramp-up starts the removal phase without adding a cell, even when `slip_warn` is high in the same cycle.
- R6: In the removal phase, one cell is removed every K cycles, where K is `decay_period` and a value of 0 acts as 1. The first removal happens K cycles after the cycle in which the count stopped rising.
- R7: Slip warnings are ignored during removal. `overshoot` is ignored in idle.
- R8: `settled` goes to 1 in the cycle the count reaches 0 at the end of removal. It returns to 0 with the next slip warning accepted in idle, and it is never 1 while cells are on.
- R9: A cycle with `enable` low returns the controller to idle with `cell_count` 0 and `settled` 0 on the next cycle.
- R10: In ramp-up, a cycle with neither a warning nor an overshoot leaves `cell_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector comparison clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous enable; low forces idle with no cells |
| slip_warn | input | 1 | Slip-imminent indication for this cycle |
| tune_up | input | 1 | 1 when the tuning voltage must rise |
| overshoot | input | 1 | VCO frequency has passed the target |
| decay_period | input | 8 | Cycles between cell removals (0 acts as 1) |
| cell_count | output | 3 | Number of extra cells switched on |
| cell_source | output | 1 | 1 = cells source current, 0 = cells sink current |
| settled | output | 1 | Acquisition finished and all cells are off |

## Verification
A state register that holds the wrong value shows up at the ports within one cycle. Either the count takes a step it should not, such as an increment during removal or after overshoot, or `settled` is raised while cells are still on. A fault in the removal spacing counter is slower to appear. It first shows up K cycles into the removal phase, as a decrement that comes too early or too late. For this reason the bench samples the count every cycle across whole ramp-downs, using several values of K, including 0 and 1. A wrongly captured polarity stays wrong for the whole acquisition, so it is checked on acquisitions started in both directions.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_RAMP_UP   = 2'd1,
    ST_RAMP_DOWN = 2'd2
  } csr_state_e;
endpackage

// File: rtl/csr_decay_timer.sv
module csr_decay_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  output logic             step
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   cnt_inc;
  logic [DIV_W:0]   period_eff;

  assign cnt_inc    = {1'b0, cnt_q} + {{DIV_W{1'b0}}, 1'b1};
  assign period_eff = (period == '0) ? {{DIV_W{1'b0}}, 1'b1} : {1'b0, period};
  assign step       = run && (cnt_inc >= period_eff);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run)
      cnt_d = step ? '0 : cnt_inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/csr_level_fsm.sv
module csr_level_fsm
  import csr_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int MAX_CELLS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             slip_warn,
  input  logic             overshoot,
  input  logic             step,
  output csr_state_e       state,
  output logic [CNT_W-1:0] count,
  output logic             first_on,
  output logic             drained
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_CELLS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  csr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    first_on = 1'b0;
    drained  = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (slip_warn) begin
            state_d  = ST_RAMP_UP;
            cnt_d    = CNT_ONE;
            first_on = 1'b1;
          end
        end
        ST_RAMP_UP: begin
          if (overshoot)
            state_d = ST_RAMP_DOWN;
          else if (slip_warn && (cnt_q < CNT_MAX))
            cnt_d = cnt_q + CNT_ONE;
        end
        ST_RAMP_DOWN: begin
          if (step) begin
            cnt_d = cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) begin
              state_d = ST_IDLE;
              drained = 1'b1;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state = state_q;
  assign count = cnt_q;
endmodule

// File: rtl/csr_cell_ctrl.sv
module csr_cell_ctrl
  import csr_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int MAX_CELLS = 7,
  parameter int DIV_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             slip_warn,
  input  logic             tune_up,
  input  logic             overshoot,
  input  logic [DIV_W-1:0] decay_period,
  output logic [CNT_W-1:0] cell_count,
  output logic             cell_source,
  output logic             settled
);
  csr_state_e state;
  logic       step, first_on, drained;
  logic       tmr_clr, tmr_run;
  logic       src_q, src_d, src_en;
  logic       set_q, set_d;

  assign tmr_run = enable && (state == ST_RAMP_DOWN);
  assign tmr_clr = !tmr_run;

  csr_decay_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .run    (tmr_run),
    .period (decay_period),
    .step   (step)
  );

  csr_level_fsm #(.CNT_W(CNT_W), .MAX_CELLS(MAX_CELLS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .slip_warn (slip_warn),
    .overshoot (overshoot),
    .step      (step),
    .state     (state),
    .count     (cell_count),
    .first_on  (first_on),
    .drained   (drained)
  );

  assign src_en = first_on;
  assign src_d  = tune_up;

  always_comb begin
    set_d = set_q;
    if (!enable)
      set_d = 1'b0;
    else if (drained)
      set_d = 1'b1;
    else if (first_on)
      set_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      if (src_en) src_q <= src_d;
      set_q <= set_d;
    end
  end

  assign cell_source = src_q;
  assign settled     = set_q;
endmodule

// File: rtl/csr_cell_ctrl_chk.sv
module csr_cell_ctrl_chk
  import csr_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int MAX_CELLS = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             slip_warn,
  input logic             overshoot,
  input csr_state_e       state,
  input logic [CNT_W-1:0] cell_count,
  input logic             cell_source,
  input logic             settled
);
  localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_CELLS);
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_IDLE && slip_warn) |=> (cell_count == CONE && !settled)); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RAMP_UP && slip_warn && !overshoot && cell_count != CMAX)
      |=> (cell_count == $past(cell_count) + CONE)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RAMP_UP && cell_count == CMAX && !overshoot) |=> (cell_count == CMAX)); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_count != '0) |=> (cell_count == '0 || $stable(cell_source))); // R4
  AST_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RAMP_UP && overshoot)
      |=> (state == ST_RAMP_DOWN && $stable(cell_count))); // R5
  AST_DOWN_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RAMP_DOWN)
      |=> (cell_count == $past(cell_count) || cell_count == $past(cell_count) - CONE)); // R7
  AST_SETTLED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (cell_count == '0)); // R8
  AST_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cell_count == '0 && !settled && state == ST_IDLE)); // R9
  AST_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state == ST_RAMP_UP && !slip_warn && !overshoot) |=> $stable(cell_count)); // R10
endmodule

bind csr_cell_ctrl csr_cell_ctrl_chk #(.CNT_W(CNT_W), .MAX_CELLS(MAX_CELLS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .slip_warn   (slip_warn),
  .overshoot   (overshoot),
  .state       (state),
  .cell_count  (cell_count),
  .cell_source (cell_source),
  .settled     (settled)
);

// File: tb/csr_cell_ctrl_bench.sv
`timescale 1ns/1ps
module csr_cell_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0, slip_warn = 1'b0, tune_up = 1'b0, overshoot = 1'b0;
  logic [7:0] decay_period = 8'd1;
  logic [2:0] cell_count;
  logic       cell_source, settled;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model state: 0 idle, 1 ramp-up, 2 ramp-down
  int m_st = 0, m_cnt = 0, m_div = 0, m_src = 0, m_set = 0;

  always #5 clk = ~clk;

  csr_cell_ctrl u_csr_cell_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slip_warn(slip_warn),
    .tune_up(tune_up), .overshoot(overshoot), .decay_period(decay_period),
    .cell_count(cell_count), .cell_source(cell_source), .settled(settled)
  );

  function automatic int eff_period(input logic [7:0] k);
    return (k == 8'd0) ? 1 : int'(k);
  endfunction

  task automatic model_step();
    if (!enable) begin
      m_st = 0; m_cnt = 0; m_div = 0; m_set = 0;
    end else begin
      case (m_st)
        0: if (slip_warn) begin m_st = 1; m_cnt = 1; m_src = tune_up; m_set = 0; end
        1: begin
          if (overshoot) begin m_st = 2; m_div = 0; end
          else if (slip_warn && m_cnt < 7) m_cnt = m_cnt + 1;
        end
        default: begin
          if (m_div + 1 >= eff_period(decay_period)) begin
            m_div = 0; m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin m_st = 0; m_set = 1; end
          end else m_div = m_div + 1;
        end
      endcase
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model(input string tag);
    check({tag, " count"}, int'(cell_count), m_cnt);
    check({tag, " source"}, int'(cell_source), m_src);
    check({tag, " settled"}, int'(settled), m_set);
  endtask

  // drive at the falling edge, let one rising edge pass, compare at next fall
  task automatic cyc(input logic en, input logic sw, input logic tu, input logic ov,
                     input string tag);
    enable = en; slip_warn = sw; tune_up = tu; overshoot = ov;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_model(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    check("R1 count", int'(cell_count), 0);
    check("R1 source", int'(cell_source), 0);
    check("R1 settled", int'(settled), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // acquisition upward, K = 3
    decay_period = 8'd3;
    cyc(1, 1, 1, 0, "R2");
    check("R2 first cell", int'(cell_count), 1);
    check("R2 polarity", int'(cell_source), 1);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, "R3 ramp");
    check("R3 reach max", int'(cell_count), 7);
    cyc(1, 1, 0, 0, "R3 saturate");
    cyc(1, 1, 0, 0, "R3 saturate");
    check("R3 held at max", int'(cell_count), 7);
    cyc(1, 0, 0, 0, "R10 steady");
    check("R10 no change", int'(cell_count), 7);
    cyc(1, 1, 0, 1, "R5 overshoot wins");
    check("R5 no add", int'(cell_count), 7);
    cyc(1, 1, 0, 0, "R7 ignore");
    cyc(1, 1, 0, 0, "R7 ignore");
    check("R6 not yet", int'(cell_count), 7);
    cyc(1, 1, 0, 0, "R6 first removal");
    check("R6 removal after K", int'(cell_count), 6);
    check("R4 polarity held", int'(cell_source), 1);
    for (int i = 0; i < 18; i++) cyc(1, i % 2 == 0, 0, 0, "R6 drain");
    check("R6 empty", int'(cell_count), 0);
    check("R8 settled set", int'(settled), 1);
    cyc(1, 0, 0, 1, "R7 idle overshoot");
    check("R7 idle overshoot ignored", int'(cell_count), 0);

    // downward acquisition, K = 0 acts as 1
    decay_period = 8'd0;
    cyc(1, 1, 0, 0, "R8 clear");
    check("R8 cleared", int'(settled), 0);
    check("R4 sink captured", int'(cell_source), 0);
    cyc(1, 1, 1, 0, "R4 later tune ignored");
    check("R4 sink kept", int'(cell_source), 0);
    cyc(1, 0, 1, 1, "R5");
    cyc(1, 0, 1, 0, "R6 K0");
    check("R6 K0 every cycle", int'(cell_count), 1);
    cyc(1, 0, 1, 0, "R6 K0");
    check("R8 settled K0", int'(settled), 1);

    // disable mid-acquisition
    cyc(1, 1, 1, 0, "R2");
    cyc(1, 1, 1, 0, "R3");
    cyc(0, 1, 1, 0, "R9");
    check("R9 cells off", int'(cell_count), 0);
    check("R9 settled low", int'(settled), 0);

    // constrained random
    for (int i = 0; i < 6000; i++) begin
      if (i % 200 == 0) decay_period = 8'($urandom_range(0, 5));
      cyc(($urandom_range(0, 99) < 98), ($urandom_range(0, 99) < 35),
          1'($urandom_range(0, 1)), ($urandom_range(0, 99) < 6), "R3 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule